// File: doc/BRIEF.md
# Bus Machine-Cycle Sequencer

This block turns one bus request from an 8-bit processor core into the timed strobe pattern of a single machine cycle on the external bus. One clock of `clk_i` is one half-cycle of the processor clock. A request names a cycle kind (opcode fetch, memory read, memory write, I/O read, I/O write, interrupt acknowledge), a 16-bit address, write data and a 2-bit length selector. The sequencer walks a chain of phases (start, optional unsampled delay, WAIT-sampled phase, optional unsampled delay, end, optional refresh), each lasting a fixed number of half-cycles. It drives address, data-out and active-high M1, memory-request, I/O-request, read, write and refresh strobes.

The sampled phase is the only place where `wait_i` matters. The WAIT input is examined at the last half-cycle of that phase. If WAIT is high there, the phase runs again for two more half-cycles. Read data is captured at the same point once WAIT is seen low. Because the optional delay can sit either before or after the sampled phase, the half-cycle at which WAIT is examined moves with the length selector. The core issues a request while `busy_o` is low and receives a one-clock `done_o` in the last half-cycle of the cycle.

Top module: `bus_cycle_seq`

## Requirements
- R1: A memory read (kind 1) with selector 0 lasts 8 half-cycles (start 3, sampled 2, end 3). `mreq_o` and `rd_o` are high and `addr_o` equals the request address for the whole cycle. WAIT is examined in half-cycle index 4, counting the first half-cycle after acceptance as index 0.
- R2: A memory write (kind 2) uses the same phase structure as a memory read. `mreq_o` and `wr_o` are high throughout, and `data_o` carries the request write data; otherwise `data_o` is 0.
- R3: For memory cycles, selector 1 inserts 2 unsampled half-cycles before the sampled phase. The total is 10 and WAIT is examined at index 6.
- R4: For memory cycles, selector 2 inserts 2 unsampled half-cycles after the sampled phase. The total is 10 and WAIT is examined at index 4.
- R5: For memory cycles, selector 3 inserts 4 unsampled half-cycles before the sampled phase. The total is 12 and WAIT is examined at index 8.
- R6: I/O read (kind 3) and I/O write (kind 4) last 10 half-cycles: start 3, forced unsampled 2, sampled 2, end 3. WAIT is examined at index 6 and the selector has no effect. `iorq_o` is high together with `rd_o` or `wr_o`.
- R7: An opcode fetch (kind 0) has start 3, sampled 2 (WAIT at index 4) and end 1, with `m1_o`, `mreq_o` and `rd_o` high. A refresh phase of 4, 6 or 8 half-cycles follows for selector 0, 1 or 2; selector 3 gives 8.
- R8: During a refresh phase, `rfsh_o` and `mreq_o` are high, `rd_o`, `wr_o` and `m1_o` are low, and `addr_o` equals `rfsh_addr_i` rather than the request address.
- R9: An interrupt acknowledge (kind 5) has start 7, sampled 2 (WAIT at index 8), end 3 and refresh 4, for 16 half-cycles. `m1_o` and `iorq_o` are high without `mreq_o` or `rd_o`, and the selector has no effect.
- R10: Each sampling point at which `wait_i` is high adds exactly 2 half-cycles. WAIT high at any other half-cycle has no effect on timing.
- R11: `done_o` is high for exactly the last half-cycle of the cycle. For reads, fetches and acknowledges, `rdata_o` then holds the value that `data_i` had in the final half-cycle of the sampled phase.
- R12: While idle, all strobes are low, `addr_o` and `data_o` are 0, and `busy_o` is low. A request is accepted only while `busy_o` is low, and `req_valid_i` during a cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Half-cycle clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken when `busy_o` is low |
| req_kind_i | input | 3 | Cycle kind: 0 fetch, 1 mem read, 2 mem write, 3 I/O read, 4 I/O write, 5 int ack |
| req_ext_i | input | 2 | Length selector (delay placement or refresh stretch) |
| req_addr_i | input | 16 | Cycle address |
| req_wdata_i | input | 8 | Write data |
| rfsh_addr_i | input | 16 | Address shown during refresh |
| busy_o | output | 1 | A cycle is in progress |
| done_o | output | 1 | Last half-cycle of the cycle |
| rdata_o | output | 8 | Captured read data |
| addr_o | output | 16 | Bus address |
| data_o | output | 8 | Bus write data |
| data_i | input | 8 | Bus read data |
| wait_i | input | 1 | Wait request from the bus |
| m1_o | output | 1 | First-cycle (fetch/acknowledge) strobe |
| mreq_o | output | 1 | Memory request strobe |
| iorq_o | output | 1 | I/O request strobe |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| rfsh_o | output | 1 | Refresh strobe |

## Verification
A wrong phase length or a misplaced phase shifts the moment `done_o` rises, so it shows within the same cycle as a wrong total length. A sampling point at the wrong half-cycle is exposed by a one-clock WAIT pulse swept across every half-cycle index: the cycle grows only when the pulse hits the real sampling point. The captured `rdata_o` also differs, because `data_i` carries a different value in each half-cycle. A wrong strobe decode or address mux is caught in the first half-cycle of the affected phase, since every strobe and the address are compared on every half-cycle.

// File: rtl/bus_cyc_pkg.sv
package bus_cyc_pkg;

  typedef enum logic [2:0] {
    CK_FETCH = 3'd0,
    CK_MRD   = 3'd1,
    CK_MWR   = 3'd2,
    CK_IORD  = 3'd3,
    CK_IOWR  = 3'd4,
    CK_IACK  = 3'd5
  } cyc_kind_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_PRE,
    PH_SAMP,
    PH_POST,
    PH_END,
    PH_RFSH
  } phase_e;

  localparam logic [1:0] EXT_STD  = 2'd0;
  localparam logic [1:0] EXT_PRE  = 2'd1;
  localparam logic [1:0] EXT_POST = 2'd2;
  localparam logic [1:0] EXT_LONG = 2'd3;

  typedef struct packed {
    cyc_kind_e  kind;
    logic [1:0] ext;
  } cyc_ctl_t;

  function automatic logic is_mem(cyc_kind_e k);
    return (k == CK_MRD) || (k == CK_MWR);
  endfunction

  function automatic logic is_io(cyc_kind_e k);
    return (k == CK_IORD) || (k == CK_IOWR);
  endfunction

  function automatic logic takes_data(cyc_kind_e k);
    return (k == CK_FETCH) || (k == CK_MRD) || (k == CK_IORD) || (k == CK_IACK);
  endfunction

endpackage

// File: rtl/bus_cyc_req_latch.sv
module bus_cyc_req_latch
  import bus_cyc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  cyc_ctl_t          req_ctl_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] data_i,
  output cyc_ctl_t          ctl_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_o   <= '{kind: CK_FETCH, ext: EXT_STD};
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (accept_i) begin
      ctl_o   <= req_ctl_i;
      addr_o  <= req_addr_i;
      wdata_o <= req_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (capture_i && takes_data(ctl_o.kind)) rdata_o <= data_i;
  end

endmodule

// File: rtl/bus_cyc_phase_ctl.sv
module bus_cyc_phase_ctl
  import bus_cyc_pkg::*;
#(
  parameter int START_HC      = 3,
  parameter int IACK_START_HC = 7,
  parameter int SAMP_HC       = 2,
  parameter int STRETCH_HC    = 2,
  parameter int LONG_PRE_HC   = 4,
  parameter int END_HC        = 3,
  parameter int FETCH_END_HC  = 1,
  parameter int RFSH_HC       = 4,
  parameter int CNT_W         = 5
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     accept_i,
  input  cyc_ctl_t req_ctl_i,
  input  cyc_ctl_t cur_ctl_i,
  input  logic     wait_i,
  output phase_e   phase_o,
  output logic     busy_o,
  output logic     capture_o,
  output logic     done_o
);

  localparam logic [CNT_W-1:0] SAMP_CNT = CNT_W'(SAMP_HC);

  function automatic int hc_of(phase_e ph, cyc_ctl_t c);
    int n;
    n = 0;
    case (ph)
      PH_START: n = (c.kind == CK_IACK) ? IACK_START_HC : START_HC;
      PH_PRE: begin
        if (is_mem(c.kind)) begin
          if (c.ext == EXT_PRE)       n = STRETCH_HC;
          else if (c.ext == EXT_LONG) n = LONG_PRE_HC;
        end else if (is_io(c.kind)) begin
          n = SAMP_HC;  // forced, never sampled
        end
      end
      PH_SAMP: n = SAMP_HC;
      PH_POST: n = (is_mem(c.kind) && c.ext == EXT_POST) ? STRETCH_HC : 0;
      PH_END:  n = (c.kind == CK_FETCH) ? FETCH_END_HC : END_HC;
      PH_RFSH: begin
        if (c.kind == CK_FETCH) begin
          case (c.ext)
            2'd0:    n = RFSH_HC;
            2'd1:    n = RFSH_HC + STRETCH_HC;
            default: n = RFSH_HC + 2 * STRETCH_HC;
          endcase
        end else if (c.kind == CK_IACK) begin
          n = RFSH_HC;
        end
      end
      default: n = 0;
    endcase
    return n;
  endfunction

  function automatic phase_e raw_next(phase_e ph);
    case (ph)
      PH_START: return PH_PRE;
      PH_PRE:   return PH_SAMP;
      PH_SAMP:  return PH_POST;
      PH_POST:  return PH_END;
      PH_END:   return PH_RFSH;
      default:  return PH_IDLE;
    endcase
  endfunction

  // next phase with zero-length phases skipped
  function automatic phase_e succ(phase_e ph, cyc_ctl_t c);
    phase_e p;
    logic   found;
    p     = raw_next(ph);
    found = 1'b0;
    for (int i = 0; i < 5; i++) begin
      if (!found) begin
        if (p == PH_IDLE || hc_of(p, c) != 0) found = 1'b1;
        else p = raw_next(p);
      end
    end
    return p;
  endfunction

  phase_e           ph_q;
  logic [CNT_W-1:0] cnt_q;
  phase_e           nxt_ph;
  logic             last_hc;
  logic             hold;

  always_comb begin
    nxt_ph    = succ(ph_q, cur_ctl_i);
    last_hc   = (ph_q != PH_IDLE) && (cnt_q == CNT_W'(1));
    hold      = (ph_q == PH_SAMP) && last_hc && wait_i;
    capture_o = (ph_q == PH_SAMP) && last_hc && !wait_i;
    done_o    = last_hc && !hold && (nxt_ph == PH_IDLE);
    busy_o    = (ph_q != PH_IDLE);
    phase_o   = ph_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else if (ph_q == PH_IDLE) begin
      if (accept_i) begin
        ph_q  <= PH_START;
        cnt_q <= CNT_W'(hc_of(PH_START, req_ctl_i));
      end
    end else if (cnt_q > CNT_W'(1)) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end else if (hold) begin
      cnt_q <= SAMP_CNT;
    end else begin
      ph_q  <= nxt_ph;
      cnt_q <= CNT_W'(hc_of(nxt_ph, cur_ctl_i));
    end
  end

  assert_wait_repeat_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_SAMP && cnt_q == CNT_W'(1) && wait_i) |=> (ph_q == PH_SAMP && cnt_q == SAMP_CNT));

  assert_done_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && ph_q == PH_IDLE));

  assert_cnt_live_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q != PH_IDLE) |-> (cnt_q != '0));

  assert_rfsh_after_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_RFSH && $past(ph_q) != PH_RFSH) |-> ($past(ph_q) == PH_END));

endmodule

// File: rtl/bus_cyc_strobe.sv
module bus_cyc_strobe
  import bus_cyc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  phase_e            phase_i,
  input  cyc_kind_e         kind_i,
  input  logic [ADDR_W-1:0] addr_q_i,
  input  logic [DATA_W-1:0] wdata_q_i,
  input  logic [ADDR_W-1:0] rfsh_addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              m1_o,
  output logic              mreq_o,
  output logic              iorq_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic              rfsh_o
);

  logic bus_ph;
  logic rf_ph;

  always_comb begin
    bus_ph = (phase_i != PH_IDLE) && (phase_i != PH_RFSH);
    rf_ph  = (phase_i == PH_RFSH);
    m1_o   = bus_ph && (kind_i == CK_FETCH || kind_i == CK_IACK);
    mreq_o = (bus_ph && (kind_i == CK_FETCH || is_mem(kind_i))) || rf_ph;
    iorq_o = bus_ph && (is_io(kind_i) || kind_i == CK_IACK);
    rd_o   = bus_ph && (kind_i == CK_FETCH || kind_i == CK_MRD || kind_i == CK_IORD);
    wr_o   = bus_ph && (kind_i == CK_MWR || kind_i == CK_IOWR);
    rfsh_o = rf_ph;
    addr_o = rf_ph ? rfsh_addr_i : (bus_ph ? addr_q_i : '0);
    data_o = wr_o ? wdata_q_i : '0;
  end

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bus_cyc_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 8,
  parameter int START_HC      = 3,
  parameter int IACK_START_HC = 7,
  parameter int SAMP_HC       = 2,
  parameter int STRETCH_HC    = 2,
  parameter int LONG_PRE_HC   = 4,
  parameter int END_HC        = 3,
  parameter int FETCH_END_HC  = 1,
  parameter int RFSH_HC       = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [2:0]        req_kind_i,
  input  logic [1:0]        req_ext_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [ADDR_W-1:0] rfsh_addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  input  logic [DATA_W-1:0] data_i,
  input  logic              wait_i,
  output logic              m1_o,
  output logic              mreq_o,
  output logic              iorq_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic              rfsh_o
);

  localparam int MAX_SUM = IACK_START_HC + RFSH_HC + 2 * STRETCH_HC + LONG_PRE_HC + START_HC;
  localparam int CNT_W   = $clog2(MAX_SUM + 1);

  cyc_ctl_t          req_ctl;
  cyc_ctl_t          cur_ctl;
  logic              accept;
  logic              capture;
  phase_e            phase;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  assign req_ctl = '{kind: cyc_kind_e'(req_kind_i), ext: req_ext_i};
  assign accept  = req_valid_i && !busy_o;

  bus_cyc_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .req_ctl_i   (req_ctl),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .capture_i   (capture),
    .data_i      (data_i),
    .ctl_o       (cur_ctl),
    .addr_o      (addr_q),
    .wdata_o     (wdata_q),
    .rdata_o     (rdata_o)
  );

  bus_cyc_phase_ctl #(
    .START_HC      (START_HC),
    .IACK_START_HC (IACK_START_HC),
    .SAMP_HC       (SAMP_HC),
    .STRETCH_HC    (STRETCH_HC),
    .LONG_PRE_HC   (LONG_PRE_HC),
    .END_HC        (END_HC),
    .FETCH_END_HC  (FETCH_END_HC),
    .RFSH_HC       (RFSH_HC),
    .CNT_W         (CNT_W)
  ) u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .req_ctl_i (req_ctl),
    .cur_ctl_i (cur_ctl),
    .wait_i    (wait_i),
    .phase_o   (phase),
    .busy_o    (busy_o),
    .capture_o (capture),
    .done_o    (done_o)
  );

  bus_cyc_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_strobe (
    .phase_i     (phase),
    .kind_i      (cur_ctl.kind),
    .addr_q_i    (addr_q),
    .wdata_q_i   (wdata_q),
    .rfsh_addr_i (rfsh_addr_i),
    .addr_o      (addr_o),
    .data_o      (data_o),
    .m1_o        (m1_o),
    .mreq_o      (mreq_o),
    .iorq_o      (iorq_o),
    .rd_o        (rd_o),
    .wr_o        (wr_o),
    .rfsh_o      (rfsh_o)
  );

  assert_rd_wr_excl_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o));

  assert_idle_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(m1_o || mreq_o || iorq_o || rd_o || wr_o || rfsh_o));

  assert_accept_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !busy_o) |=> busy_o);

  assert_rfsh_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rfsh_o |-> (!rd_o && !wr_o && !m1_o && mreq_o && addr_o == rfsh_addr_i));

  assert_iack_no_mreq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iorq_o && m1_o) |-> (!mreq_o && !rd_o));

endmodule

// File: tb/bus_cycle_seq_bench.sv
`timescale 1ns/1ps
module bus_cycle_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_kind = '0;
  logic [1:0]  req_ext = '0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [15:0] rfsh_addr = '0;
  logic [7:0]  data_in = '0;
  logic        wait_in = 1'b0;
  logic        busy, done, m1, mreq, iorq, rd, wr, rfsh;
  logic [7:0]  rdata, data_out;
  logic [15:0] addr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  bus_cycle_seq u_bus_cycle_seq (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_valid_i (req_valid),
    .req_kind_i  (req_kind),
    .req_ext_i   (req_ext),
    .req_addr_i  (req_addr),
    .req_wdata_i (req_wdata),
    .rfsh_addr_i (rfsh_addr),
    .busy_o      (busy),
    .done_o      (done),
    .rdata_o     (rdata),
    .addr_o      (addr),
    .data_o      (data_out),
    .data_i      (data_in),
    .wait_i      (wait_in),
    .m1_o        (m1),
    .mreq_o      (mreq),
    .iorq_o      (iorq),
    .rd_o        (rd),
    .wr_o        (wr),
    .rfsh_o      (rfsh)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(int k, int e);
    case (k)
      0: return "R7";
      1, 2: begin
        if (e == 1) return "R3";
        if (e == 2) return "R4";
        if (e == 3) return "R5";
        return (k == 1) ? "R1" : "R2";
      end
      3, 4: return "R6";
      default: return "R9";
    endcase
  endfunction

  function automatic int start_hc(int k); return (k == 5) ? 7 : 3; endfunction
  function automatic int pre_hc(int k, int e);
    if (k == 1 || k == 2) return (e == 1) ? 2 : (e == 3) ? 4 : 0;
    if (k == 3 || k == 4) return 2;
    return 0;
  endfunction
  function automatic int post_hc(int k, int e); return ((k == 1 || k == 2) && e == 2) ? 2 : 0; endfunction
  function automatic int end_hc(int k); return (k == 0) ? 1 : 3; endfunction
  function automatic int rf_hc(int k, int e);
    if (k == 0) return 4 + 2 * ((e > 2) ? 2 : e);
    if (k == 5) return 4;
    return 0;
  endfunction
  function automatic int samp_idx(int k, int e); return start_hc(k) + pre_hc(k, e) + 1; endfunction
  function automatic int bus_len(int k, int e, int n);
    return start_hc(k) + pre_hc(k, e) + 2 + 2 * n + post_hc(k, e) + end_hc(k);
  endfunction

  // one cycle: pulse = single-clock WAIT index (-1 none), hold = WAIT hits at consecutive sampling points
  task automatic run_cyc(input int k, input int e, input int pulse, input int hold, input bit glitch);
    int s, n, bl, total, got, bad;
    logic [15:0] av;
    logic [7:0]  wv;
    logic [5:0]  exp_s, act_s;
    logic [15:0] exp_a;
    logic [7:0]  exp_d;
    string tag;
    tag = tag_of(k, e);
    s   = samp_idx(k, e);
    n   = hold + ((pulse == s) ? 1 : 0);
    bl  = bus_len(k, e, n);
    total = bl + rf_hc(k, e);
    av  = 16'hA000 ^ 16'(k * 16'h0123) ^ 16'(e * 16'h1010) ^ 16'(pulse & 16'hff);
    wv  = 8'(8'h3C + k * 8'h11 + e);
    got = -1;
    bad = 0;
    @(negedge clk);
    req_valid = 1'b1; req_kind = 3'(k); req_ext = 2'(e);
    req_addr = av; req_wdata = wv; rfsh_addr = ~av;
    @(negedge clk);
    req_valid = 1'b0;
    for (int h = 0; h < 60; h++) begin
      wait_in = (h == pulse) || (hold > 0 && h >= s && h < s + 2 * hold && ((h - s) % 2 == 0));
      data_in = 8'(8'h40 + h);
      if (glitch && h == 3) begin req_valid = 1'b1; req_kind = 3'd5; req_ext = 2'd3; end
      else req_valid = 1'b0;
      if (h < bl) begin
        exp_s = {(k == 0 || k == 5), (k <= 2), (k >= 3), (k == 0 || k == 1 || k == 3), (k == 2 || k == 4), 1'b0};
        exp_a = av;
        exp_d = (k == 2 || k == 4) ? wv : 8'h00;
      end else begin
        exp_s = 6'b010001;
        exp_a = ~av;
        exp_d = 8'h00;
      end
      act_s = {m1, mreq, iorq, rd, wr, rfsh};
      if (act_s !== exp_s || addr !== exp_a || data_out !== exp_d) begin
        if (bad == 0) begin
          chk(1'b0, (h < bl) ? tag : "R8", $sformatf("strobes/addr at hc %0d", h),
              int'({act_s, addr}), int'({exp_s, exp_a}));
        end
        bad++;
      end
      if (done) begin got = h; break; end
      @(negedge clk);
    end
    wait_in = 1'b0;
    req_valid = 1'b0;
    if (bad == 0) chk(1'b1, tag, "strobes", 0, 0);
    chk(got == total - 1, (pulse >= 0 || hold > 0) ? "R10" : tag,
        $sformatf("done index kind %0d sel %0d pulse %0d hold %0d", k, e, pulse, hold), got, total - 1);
    @(negedge clk);
    chk(!busy && !done && {m1, mreq, iorq, rd, wr, rfsh} == 6'b0 && addr == 16'h0 && data_out == 8'h0,
        "R12", "idle after cycle", int'({busy, done, m1, mreq, iorq, rd, wr, rfsh}), 0);
    if (k == 0 || k == 1 || k == 3 || k == 5)
      chk(rdata == 8'(8'h40 + s + 2 * n), "R11", "captured read data", rdata, 8'(8'h40 + s + 2 * n));
  endtask

  initial begin
    int total;
    repeat (3) @(negedge clk);
    chk(!busy && !done && {m1, mreq, iorq, rd, wr, rfsh} == 6'b0 && addr == 16'h0 && rdata == 8'h0,
        "R12", "reset state", int'({busy, m1, mreq, iorq, rd, wr, rfsh}), 0);
    req_valid = 1'b1;
    @(negedge clk);
    chk(!busy, "R12", "no accept in reset", busy, 0);
    req_valid = 1'b0;
    rst_n = 1'b1;
    for (int k = 0; k < 6; k++) begin
      for (int e = 0; e < 4; e++) begin
        run_cyc(k, e, -1, 0, 1'b0);
        total = bus_len(k, e, 0) + rf_hc(k, e);
        for (int p = 0; p < total; p++) run_cyc(k, e, p, 0, 1'b0);
        run_cyc(k, e, -1, 3, 1'b0);
        run_cyc(k, e, -1, 0, 1'b1);
      end
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule